// File: doc/BRIEF.md
# Code Memory Source Selector

This block sits between the code-space reader of a small processor core (instruction fetch or table read) and the two places where program bytes can live. One is a 4 KB on-chip ROM, and the other is an external program memory reached over a request/acknowledge bus. Each read carries a 16-bit address into one shared code space running from 0x0000 to 0xFFFF. The block decides which memory serves the read, drives that memory's port, and returns the byte together with a one-cycle valid flag.

The decision uses the address and a board-level strap input. Addresses from 0x1000 upward always go to the external bus. The low 4 KB window is served by the on-chip ROM when the strap is high, and by external memory when the strap is low. The strap level is captured once, on the first clock after reset is released, and is then held. Fetches and table reads follow the same rule. Only one read may be in flight at a time. A request made while a read is pending is dropped, and the busy output shows this.

The on-chip ROM is a synchronous array outside this block. It returns the addressed byte on the clock after its enable is sampled.

Top module: `code_mem_steer`

## Requirements
- R1: During and right after reset, rd_valid_o, busy_o, rom_en_o and ext_req_o are 0 and rd_data_o is 0x00.
- R2: With the captured strap at 1, a request for an address in 0x0000..0x0FFF raises rom_en_o in the request cycle, with rom_addr_o equal to address bits [11:0]. rd_valid_o and the ROM byte appear on the next cycle, and ext_req_o stays low.
- R3: A request for an address in 0x1000..0xFFFF is served by the external bus whatever the strap level, and rom_en_o stays low.
- R4: With the captured strap at 0, every address, including 0x0000..0x0FFF, is served externally, and rom_en_o never rises. rom_en_o and ext_req_o are never high together.
- R5: An external read raises ext_req_o on the cycle after the request, with ext_addr_o equal to the request address. Both hold until ext_ack_i is sampled high. rd_valid_o follows one cycle later and carries the ext_data_i byte captured with the acknowledge, which gives a minimum latency of 2 cycles.
- R6: While a read is pending, busy_o is 1, and a new request starts no ROM or external access.
- R7: The strap is sampled only on the first clock after reset release. Later changes to strap_i do not change the routing until the next reset.
- R8: rd_valid_o is a single-cycle pulse for each accepted read. rd_data_o is 0x00 whenever rd_valid_o is 0.
- R9: An acknowledge that arrives while no external read is pending produces no rd_valid_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_i | input | 1 | Low-window source strap: 1 selects on-chip ROM |
| rd_req_i | input | 1 | Code read request |
| rd_addr_i | input | 16 | Code address |
| busy_o | output | 1 | A read is pending and new requests are dropped |
| rd_data_o | output | 8 | Returned byte, 0 when not valid |
| rd_valid_o | output | 1 | One-cycle return strobe |
| rom_en_o | output | 1 | On-chip ROM read enable |
| rom_addr_o | output | 12 | On-chip ROM address |
| rom_data_i | input | 8 | On-chip ROM byte, one cycle after enable |
| ext_req_o | output | 1 | External bus request |
| ext_addr_o | output | 16 | External bus address |
| ext_ack_i | input | 1 | External bus acknowledge |
| ext_data_i | input | 8 | External bus byte, valid with acknowledge |

## Verification
An on-chip read is due exactly one cycle after its request. An external read is due one cycle after the sampled acknowledge. The bench's responder raises the acknowledge a programmed number of cycles after it sees the request, so the external latency is that delay plus three cycles. For every read, the bench drives inputs on the falling edge and counts falling edges until valid. It compares that count with the expected latency and compares the byte with a value computed from the address. On the following falling edge it confirms that valid and data have returned to zero. Per-edge counters of ROM enables and external request starts confirm that exactly one memory was touched.

// File: rtl/code_steer_pkg.sv
package code_steer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ROM      = 2'd1,
        ST_EXT_WAIT = 2'd2,
        ST_EXT_DONE = 2'd3
    } rd_state_e;

endpackage

// File: rtl/code_strap_latch.sv
module code_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_i,
    output logic strap_eff_o
);

    typedef struct packed {
        logic seen;
        logic lvl;
    } strap_regs_t;

    strap_regs_t s_d;
    strap_regs_t s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.seen) begin
            s_d.seen = 1'b1;
            s_d.lvl  = strap_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // The first edge after reset uses the live level, which is also what gets captured.
    assign strap_eff_o = s_q.seen ? s_q.lvl : strap_i;

    p_strap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.seen |=> (s_q.seen && $stable(s_q.lvl)));

endmodule

// File: rtl/code_region_decode.sv
module code_region_decode #(
    parameter int ADDR_W = 16,
    parameter int ROM_AW = 12
) (
    input  logic [ADDR_W-ROM_AW-1:0] hi_addr_i,
    input  logic                     strap_eff_i,
    output logic                     onchip_o
);

    localparam int HI_W = ADDR_W - ROM_AW;

    logic in_low_window;

    // The low window is the range in which every bit above the ROM index is zero.
    assign in_low_window = (hi_addr_i == {HI_W{1'b0}});
    assign onchip_o      = strap_eff_i && in_low_window;

endmodule

// File: rtl/code_read_fsm.sv
module code_read_fsm
    import code_steer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int ROM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              onchip_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              rom_en_o,
    output logic [ROM_AW-1:0] rom_addr_o,
    input  logic [DATA_W-1:0] rom_data_i,
    output logic              ext_req_o,
    output logic [ADDR_W-1:0] ext_addr_o,
    input  logic              ext_ack_i,
    input  logic [DATA_W-1:0] ext_data_i
);

    typedef struct packed {
        rd_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } fsm_regs_t;

    fsm_regs_t r_d;
    fsm_regs_t r_q;
    logic      idle;

    assign idle = (r_q.st == ST_IDLE);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    if (onchip_i) begin
                        r_d.st = ST_ROM;
                    end else begin
                        r_d.st   = ST_EXT_WAIT;
                        r_d.addr = addr_i;
                    end
                end
            end
            ST_ROM: begin
                r_d.st = ST_IDLE;
            end
            ST_EXT_WAIT: begin
                if (ext_ack_i) begin
                    r_d.st   = ST_EXT_DONE;
                    r_d.data = ext_data_i;
                end
            end
            ST_EXT_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = !idle;
    assign rom_en_o   = idle && req_i && onchip_i;
    assign rom_addr_o = addr_i[ROM_AW-1:0];
    assign ext_req_o  = (r_q.st == ST_EXT_WAIT);
    assign ext_addr_o = r_q.addr;
    assign rd_valid_o = (r_q.st == ST_ROM) || (r_q.st == ST_EXT_DONE);

    always_comb begin
        rd_data_o = '0;
        if (r_q.st == ST_ROM) begin
            rd_data_o = rom_data_i;
        end else if (r_q.st == ST_EXT_DONE) begin
            rd_data_o = r_q.data;
        end
    end

    p_rom_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en_o |=> (rd_valid_o && !ext_req_o));

    p_no_dual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_en_o && ext_req_o));

    p_ext_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_o && !ext_ack_i) |=> (ext_req_o && $stable(ext_addr_o) && !rd_valid_o));

    p_ext_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_o && ext_ack_i) |=> (rd_valid_o && !ext_req_o));

    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !rom_en_o);

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

    p_spurious_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_req_o && !rom_en_o) |=> !rd_valid_o || $past(busy_o));

endmodule

// File: rtl/code_mem_steer.sv
module code_mem_steer
    import code_steer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int ROM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              rom_en_o,
    output logic [ROM_AW-1:0] rom_addr_o,
    input  logic [DATA_W-1:0] rom_data_i,
    output logic              ext_req_o,
    output logic [ADDR_W-1:0] ext_addr_o,
    input  logic              ext_ack_i,
    input  logic [DATA_W-1:0] ext_data_i
);

    localparam int HI_W = ADDR_W - ROM_AW;

    logic strap_eff;
    logic onchip;

    code_strap_latch u_strap (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap_i),
        .strap_eff_o (strap_eff)
    );

    code_region_decode #(
        .ADDR_W (ADDR_W),
        .ROM_AW (ROM_AW)
    ) u_decode (
        .hi_addr_i   (rd_addr_i[ADDR_W-1:ROM_AW]),
        .strap_eff_i (strap_eff),
        .onchip_o    (onchip)
    );

    code_read_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ROM_AW (ROM_AW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (rd_req_i),
        .addr_i     (rd_addr_i),
        .onchip_i   (onchip),
        .busy_o     (busy_o),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .rom_en_o   (rom_en_o),
        .rom_addr_o (rom_addr_o),
        .rom_data_i (rom_data_i),
        .ext_req_o  (ext_req_o),
        .ext_addr_o (ext_addr_o),
        .ext_ack_i  (ext_ack_i),
        .ext_data_i (ext_data_i)
    );

    p_high_external_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en_o |-> (rd_addr_i[ADDR_W-1:ROM_AW] == {HI_W{1'b0}}));

endmodule

// File: tb/code_mem_steer_tb.sv
`timescale 1ns/1ps
module code_mem_steer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_i = 1'b1;
    logic        rd_req_i = 1'b0;
    logic [15:0] rd_addr_i = '0;
    logic        busy_o;
    logic [7:0]  rd_data_o;
    logic        rd_valid_o;
    logic        rom_en_o;
    logic [11:0] rom_addr_o;
    logic [7:0]  rom_data_i = '0;
    logic        ext_req_o;
    logic [15:0] ext_addr_o;
    logic        ext_ack_r = 1'b0;
    logic        spur_ack = 1'b0;
    logic [7:0]  ext_data_i = '0;
    logic        ext_ack_i;

    int checks = 0;
    int errors = 0;
    int ext_dly = 0;
    int dly_cnt = 0;
    int rom_cnt = 0;
    int ext_cnt = 0;
    logic ext_prev = 1'b0;
    logic [7:0] rom_mem [4096];

    assign ext_ack_i = ext_ack_r | spur_ack;

    always #2.5 clk = ~clk;

    code_mem_steer u_dut (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
        .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i),
        .busy_o(busy_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
        .rom_en_o(rom_en_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
        .ext_req_o(ext_req_o), .ext_addr_o(ext_addr_o),
        .ext_ack_i(ext_ack_i), .ext_data_i(ext_data_i)
    );

    function automatic logic [7:0] rom_val(input logic [11:0] a);
        return 8'((a * 7 + 3) ^ (a >> 8));
    endfunction

    function automatic logic [7:0] ext_val(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'h5A;
    endfunction

    // Synchronous on-chip ROM model
    always @(posedge clk) begin
        if (rom_en_o) rom_data_i <= rom_mem[rom_addr_o];
    end

    // External responder: acknowledge ext_dly cycles after seeing the request
    always @(posedge clk) begin
        if (ext_ack_r) begin
            ext_ack_r <= 1'b0;
            dly_cnt   <= 0;
        end else if (ext_req_o) begin
            if (dly_cnt >= ext_dly) begin
                ext_ack_r  <= 1'b1;
                ext_data_i <= ext_val(ext_addr_o);
            end else begin
                dly_cnt <= dly_cnt + 1;
            end
        end
    end

    // Access monitor
    always @(posedge clk) begin
        if (rom_en_o) rom_cnt = rom_cnt + 1;
        if (ext_req_o && !ext_prev) ext_cnt = ext_cnt + 1;
        ext_prev = ext_req_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_i = strap;
        rd_req_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [15:0] a, input bit exp_rom, input int dly, input string req);
        int k;
        int lat;
        logic [7:0] exp_data;
        ext_dly = dly;
        @(negedge clk);
        rom_cnt = 0;
        ext_cnt = 0;
        rd_req_i = 1'b1;
        rd_addr_i = a;
        #1;
        chk(rom_en_o == exp_rom, req, rom_en_o, exp_rom);
        if (exp_rom) chk(rom_addr_o == a[11:0], req, rom_addr_o, a[11:0]);
        @(negedge clk);
        rd_req_i = 1'b0;
        k = 1;
        while (!rd_valid_o && k < 60) begin
            @(negedge clk);
            k++;
        end
        lat = exp_rom ? 1 : 3 + dly;
        exp_data = exp_rom ? rom_val(a[11:0]) : ext_val(a);
        chk(k == lat, {req, " latency"}, k, lat);
        chk(rd_data_o == exp_data, {req, " data"}, rd_data_o, exp_data);
        @(negedge clk);
        chk(!rd_valid_o && rd_data_o == 8'h00, "R8 pulse/zero", {rd_valid_o, rd_data_o}, 0);
        chk(rom_cnt == (exp_rom ? 1 : 0), {req, " rom accesses"}, rom_cnt, exp_rom);
        chk(ext_cnt == (exp_rom ? 0 : 1), {req, " ext accesses"}, ext_cnt, !exp_rom);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) rom_mem[i] = rom_val(12'(i));
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!rd_valid_o && !busy_o && !rom_en_o && !ext_req_o && rd_data_o == 0, "R1 in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_valid_o && !busy_o && !rom_en_o && !ext_req_o && rd_data_o == 0, "R1 after reset", 0, 0);

        // R2: exhaustive on-chip window, strap high
        do_reset(1'b1);
        for (int a = 0; a < 4096; a++) do_read(16'(a), 1'b1, 0, "R2 onchip");

        // R3: high region with strap high, varied acknowledge delays
        for (int i = 0; i < 240; i++) do_read(16'(16'h1000 + i * 16'h00F7), 1'b0, i % 4, "R3 high ext");
        do_read(16'h1000, 1'b0, 0, "R3 boundary low");
        do_read(16'hFFFF, 1'b0, 2, "R3 top");
        do_read(16'h0FFF, 1'b1, 0, "R2 boundary");

        // R5: minimum external latency and long acknowledge delay
        do_read(16'h4321, 1'b0, 0, "R5 min");
        do_read(16'h8765, 1'b0, 9, "R5 long");

        // R9: spurious acknowledge while idle
        @(negedge clk);
        spur_ack = 1'b1;
        @(negedge clk);
        spur_ack = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(!rd_valid_o, "R9 spurious ack", rd_valid_o, 0);
            @(negedge clk);
        end

        // R6: request while an external read is pending
        ext_dly = 4;
        rom_cnt = 0;
        ext_cnt = 0;
        rd_req_i = 1'b1;
        rd_addr_i = 16'h2000;
        @(negedge clk);
        rd_addr_i = 16'h0010;
        #1;
        chk(busy_o == 1'b1, "R6 busy", busy_o, 1);
        chk(rom_en_o == 1'b0, "R6 no rom while busy", rom_en_o, 0);
        @(negedge clk);
        rd_req_i = 1'b0;
        begin
            int k;
            k = 0;
            while (!rd_valid_o && k < 60) begin
                @(negedge clk);
                k++;
            end
        end
        chk(rd_data_o == ext_val(16'h2000), "R6 first read data", rd_data_o, ext_val(16'h2000));
        @(negedge clk);
        chk(rom_cnt == 0 && ext_cnt == 1, "R6 single access", rom_cnt * 16 + ext_cnt, 1);
        chk(!busy_o, "R6 idle after", busy_o, 0);

        // R4: strap low, every address external
        do_reset(1'b0);
        for (int i = 0; i < 256; i++) do_read(16'(i * 16'h0101), 1'b0, i % 3, "R4 strap0");
        do_read(16'h0FFF, 1'b0, 1, "R4 boundary");
        do_read(16'h0000, 1'b0, 0, "R4 zero");

        // R7: strap changes after reset release are ignored
        strap_i = 1'b1;
        do_read(16'h0005, 1'b0, 0, "R7 strap0 held");
        do_reset(1'b1);
        strap_i = 1'b0;
        do_read(16'h0005, 1'b1, 0, "R7 strap1 held");
        do_read(16'h0ABC, 1'b1, 0, "R7 strap1 held 2");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule